// File: doc/BRIEF.md
# Handshaked PHY Register Access Bridge

This block is the PHY-side end of an indirect path into a bank of 16-bit PHY registers that have no memory-mapped address of their own. A requester writes a 32-bit control word and reads back a 32-bit status word. The control word carries a 16-bit value field and four request strobes: latch-address, latch-data, commit-write and fetch-read. Every strobe is a full four-phase exchange. The requester raises exactly one strobe. The bridge performs the action and raises its acknowledge. The requester then clears the strobe, and the bridge drops the acknowledge.

A register write takes three exchanges: latch the address, latch the data, then commit. A read takes two: latch the address, then fetch. The fetched value sits in the status word for as long as the acknowledge stays high. The bridge keeps a small parameterised register file that stands in for the PHY registers.

A programmable delay input stretches every acknowledge edge. A requester's give-up-after-N-polls path can therefore be exercised against slow responses.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset the status word reads all zeros, with the acknowledge low and every register of the file zero.
- R2: Control bits 15:0 carry the value or address, bit 16 is latch-address, bit 17 latch-data, bit 18 commit-write, bit 19 fetch-read; status bits 15:0 return read data, bit 16 is the acknowledge and bits 31:17 are always zero.
- R3: The acknowledge rises only in answer to a single strobe, stays high while any strobe bit is set, and falls only after all strobe bits are clear.
- R4: With delay input D, the acknowledge is seen high after the (D+2)th rising clock edge counted from the first edge that samples the strobe, and low after the (D+2)th edge counted from the first edge that samples all strobes clear.
- R5: A fetch-read returns the register selected by the latched address, and that value does not change while the acknowledge is high.
- R6: A control word with two or more strobe bits set is ignored: no acknowledge, and the latched address, latched data and register file are unchanged.
- R7: A commit-write issued with no address latched since reset updates register 0.
- R8: Only the low log2(NREGS) bits of the latched address select a register; higher address bits are ignored.
- R9: A commit-write stores the most recently latched data at the most recently latched address, and both latches persist across later exchanges until overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Control word: value field and four strobes |
| ack_dly | input | DLY_W | Extra cycles inserted before each acknowledge edge |
| stat_word | output | 32 | Status word: read data and acknowledge |

## Verification
A wrong handshake state shows as an acknowledge that rises with no strobe, falls while a strobe is still held, or misses the D+2 edge window. It is visible within D+2 cycles of the offending control word. A corrupted address or data latch does not show at once. It first appears at the next fetch-read of the affected register, so the stimulus pairs every write with a later read. It also mixes fetches that reuse a stale address with aliased addresses and multi-strobe words.

// File: rtl/phy_br_pkg.sv
package phy_br_pkg;
  // Strobe positions inside the control word
  localparam int STRB_BASE = 16;
  localparam int STRB_N    = 4;
  localparam int S_CAPA    = 0;
  localparam int S_CAPD    = 1;
  localparam int S_WR      = 2;
  localparam int S_RD      = 3;
  // Acknowledge position inside the status word
  localparam int ACK_BIT   = 16;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_RISE = 2'd1,
    HS_HIGH = 2'd2,
    HS_FALL = 2'd3
  } hs_state_e;
endpackage

// File: rtl/phy_br_hs.sv
module phy_br_hs
  import phy_br_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STRB_N-1:0] strb,
  input  logic [DLY_W-1:0]  dly,
  output logic              ack,
  output logic              busy,
  output logic              fire,
  output logic [STRB_N-1:0] op
);
  hs_state_e         st_q, st_d;
  logic [DLY_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic [STRB_N-1:0] op_d;
  logic              op_en;
  logic              single;

  assign single = (strb != '0) && ((strb & (strb - STRB_N'(1))) == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    op_d   = op;
    op_en  = 1'b0;
    fire   = 1'b0;
    unique case (st_q)
      HS_IDLE: if (single) begin
        st_d = HS_RISE; cnt_d = dly; cnt_en = 1'b1;
        op_d = strb;    op_en = 1'b1;
      end
      HS_RISE: if (cnt_q == '0) begin
        st_d = HS_HIGH; fire = 1'b1;
      end else begin
        cnt_d = cnt_q - DLY_W'(1); cnt_en = 1'b1;
      end
      HS_HIGH: if (strb == '0) begin
        st_d = HS_FALL; cnt_d = dly; cnt_en = 1'b1;
      end
      HS_FALL: if (cnt_q == '0) begin
        st_d = HS_IDLE;
      end else begin
        cnt_d = cnt_q - DLY_W'(1); cnt_en = 1'b1;
      end
      default: st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= HS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     op <= '0;
    else if (op_en) op <= op_d;
  end

  assign ack  = (st_q == HS_HIGH) || (st_q == HS_FALL);
  assign busy = (st_q != HS_IDLE);
endmodule

// File: rtl/phy_br_regs.sv
module phy_br_regs
  import phy_br_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREGS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [STRB_N-1:0] op,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDXW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [DATA_W-1:0]             addr_q, data_q, rdata_q;
  logic [NREGS-1:0][DATA_W-1:0]  bank_q;
  logic [IDXW-1:0]               idx;
  logic                          addr_en, data_en, wr_en, rd_en;

  assign idx     = addr_q[IDXW-1:0];
  assign addr_en = fire && op[S_CAPA];
  assign data_en = fire && op[S_CAPD];
  assign wr_en   = fire && op[S_WR];
  assign rd_en   = fire && op[S_RD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= din;
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_bank
    logic we;
    assign we = wr_en && (idx == IDXW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bank_q[g] <= '0;
      else if (we) bank_q[g] <= data_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= bank_q[idx];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge
  import phy_br_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      ctrl_word,
  input  logic [DLY_W-1:0] ack_dly,
  output logic [31:0]      stat_word
);
  localparam int DATA_W = 16;

  logic              ack, busy, fire;
  logic [STRB_N-1:0] op;
  logic [DATA_W-1:0] rdata;

  phy_br_hs #(.DLY_W(DLY_W)) u_hs (
    .clk  (clk),
    .rst_n(rst_n),
    .strb (ctrl_word[STRB_BASE +: STRB_N]),
    .dly  (ack_dly),
    .ack  (ack),
    .busy (busy),
    .fire (fire),
    .op   (op)
  );

  phy_br_regs #(.DATA_W(DATA_W), .NREGS(NREGS)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (fire),
    .op   (op),
    .din  (ctrl_word[DATA_W-1:0]),
    .rdata(rdata)
  );

  assign stat_word = {15'd0, ack, rdata};
endmodule

// File: rtl/phy_reg_bridge_chk.sv
module phy_reg_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctrl_word,
  input logic [31:0] stat_word,
  input logic        busy,
  input logic        fire,
  input logic [3:0]  op
);
  // R3: acknowledge held while any strobe is set
  assert_ack_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[16] && ctrl_word[19:16] != 4'd0) |=> stat_word[16]);

  // R3: no acknowledge from idle without a strobe
  assert_no_spurious_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctrl_word[19:16] == 4'd0) |=> !stat_word[16]);

  // R6: several strobes at once leave the bridge idle
  assert_multi_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $countones(ctrl_word[19:16]) > 1) |=> (!busy && !stat_word[16]));

  // R5: read data steady while acknowledge stays high
  assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[16] && $past(stat_word[16])) |-> $stable(stat_word[15:0]));

  // R2: upper status bits stay zero
  assert_stat_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[31:17] == 15'd0);

  // R6: an action fires for exactly one strobe kind
  assert_fire_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ($countones(op) == 1));
endmodule

bind phy_reg_bridge phy_reg_bridge_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctrl_word(ctrl_word),
  .stat_word(stat_word),
  .busy     (busy),
  .fire     (fire),
  .op       (op)
);

// File: tb/phy_reg_bridge_tb.sv
`timescale 1ns/1ps
module phy_reg_bridge_tb;
  localparam int NREGS = 8;
  localparam int DLY_W = 8;
  localparam int CAPA = 16, CAPD = 17, WR = 18, RD = 19;

  logic             clk;
  logic             rst_n;
  logic [31:0]      ctrl_word;
  logic [DLY_W-1:0] ack_dly;
  logic [31:0]      stat_word;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  logic [15:0] model [NREGS];

  phy_reg_bridge #(.NREGS(NREGS), .DLY_W(DLY_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
    .ack_dly(ack_dly), .stat_word(stat_word));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int ref_idx(input logic [15:0] a);
    return int'(a) % NREGS;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // One four-phase exchange; returns read data seen during the acknowledge
  task automatic xchg(input int bitn, input logic [15:0] val, input int dly,
                      output logic [15:0] rd);
    int n;
    ack_dly   = DLY_W'(dly);
    ctrl_word = (32'd1 << bitn) | {16'd0, val};
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end
    while (!stat_word[16] && n < 600);
    check(n == dly + 2, "R4 rise latency", n, dly + 2);
    check(stat_word[31:17] == 15'd0, "R2 status upper bits", stat_word[31:17], 0);
    rd = stat_word[15:0];
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(stat_word[16] == 1'b1, "R3 ack held with strobe", stat_word[16], 1);
      check(stat_word[15:0] == rd, "R5 read data stable", stat_word[15:0], rd);
    end
    ctrl_word = {16'd0, val};
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end
    while (stat_word[16] && n < 600);
    check(n == dly + 2, "R4 fall latency", n, dly + 2);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d, input int dly);
    logic [15:0] rd;
    xchg(CAPA, a, dly, rd);
    xchg(CAPD, d, dly, rd);
    xchg(WR, 16'h0, dly, rd);
    model[ref_idx(a)] = d;
  endtask

  task automatic do_read(input logic [15:0] a, input int dly, input string req);
    logic [15:0] rd;
    xchg(CAPA, a, dly, rd);
    xchg(RD, 16'h0, dly, rd);
    check(rd == model[ref_idx(a)], req, rd, model[ref_idx(a)]);
  endtask

  initial begin
    logic [15:0] rd;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NREGS; i++) model[i] = 16'h0;
    rst_n = 1'b0; ctrl_word = 32'h0; ack_dly = '0;
    repeat (3) @(negedge clk);
    check(stat_word == 32'h0, "R1 reset status", stat_word, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(stat_word == 32'h0, "R1 status after release", stat_word, 0);

    // R7: write with no address latched lands in register 0
    xchg(CAPD, 16'hBEEF, 0, rd);
    xchg(WR, 16'h0, 0, rd);
    model[0] = 16'hBEEF;
    xchg(RD, 16'h0, 1, rd);
    check(rd == 16'hBEEF, "R7 write before address goes to reg0", rd, 16'hBEEF);
    do_read(16'h0002, 0, "R1 register reset value");

    // R6: multi-strobe word ignored
    do_write(16'h0005, 16'h1234, 2);
    ctrl_word = (32'd1 << CAPA) | (32'd1 << CAPD) | (32'd1 << WR) | 32'h0002;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(stat_word[16] == 1'b0, "R6 no ack on multi strobe", stat_word[16], 0);
    end
    ctrl_word = 32'h0;
    @(negedge clk);
    xchg(RD, 16'h0, 0, rd);
    check(rd == 16'h1234, "R6 address latch unchanged", rd, 16'h1234);
    xchg(WR, 16'h0, 0, rd);   // commits old data latch to addr 5
    do_read(16'h0002, 0, "R6 reg2 untouched");
    do_read(16'h0005, 0, "R6 data latch unchanged");

    // R8: aliasing on low index bits
    do_write(16'h00F9, 16'hA5A5, 1);
    do_read(16'h0001, 1, "R8 upper address bits ignored");

    // R9: latches persist
    do_write(16'h0003, 16'h1111, 0);
    xchg(CAPD, 16'h2222, 0, rd);
    xchg(WR, 16'h0, 0, rd);
    model[3] = 16'h2222;
    do_read(16'h0003, 0, "R9 latest data at latched address");
    xchg(CAPA, 16'h0004, 0, rd);
    xchg(WR, 16'h0, 0, rd);
    model[4] = 16'h2222;
    do_read(16'h0004, 0, "R9 data latch persists");

    // R4 long delay
    do_write(16'h0006, 16'h0F0F, 37);
    do_read(16'h0006, 37, "R4 long-delay read");

    // Random mix
    for (int i = 0; i < 60; i++) begin
      logic [15:0] a, d;
      int dly;
      a   = 16'($urandom);
      d   = 16'($urandom);
      dly = int'($urandom % 6);
      if ($urandom % 2 == 0) do_write(a, d, dly);
      else                   do_read(a, dly, "R5 random read");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule